// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 16-bit serial-input converter. A host sends each code word over a three-wire link. An active-low select line marks the start and end of a frame. Data is sampled on each rising edge of the serial clock, and the first bit sent is the most significant. A frame that carries exactly one full word updates an input register. The code that reaches the converter is held in a second register, the DAC register. That register changes only when the active-low load line allows it.

An active-low clear line acts on its falling edge. The edge drives the DAC register to midscale at once. For as long as clear stays low, every load request is refused. The block runs on a single system clock. The serial clock, serial data, select, load and clear lines are each brought in through a two-flop synchronizer. Serial clock edges are found by comparing consecutive synchronized samples.

Top module: `serial_dac_front`

## Requirements
- R1: After synchronous reset, `dac_code` reads midscale, 16'h8000, and the input register also holds 16'h8000.
- R2: A frame of exactly 16 rising serial clock edges while `cs_n` is low loads the input register. The first bit sent becomes bit 15. With `ldac_n` high, `dac_code` does not change.
- R3: While `ldac_n` is low and `clr_n` is high, `dac_code` takes the input register contents.
- R4: A frame with fewer than 16 serial clock rising edges leaves the input register unchanged.
- R5: A frame with more than 16 serial clock rising edges leaves the input register unchanged.
- R6: Serial clock edges while `cs_n` is high shift nothing. They do not disturb the next frame.
- R7: A falling edge on `clr_n` sets `dac_code` to 16'h8000.
- R8: While `clr_n` is low, `ldac_n` has no effect on `dac_code`. If `ldac_n` is still low when `clr_n` returns high, `dac_code` takes the input register. Words received during the clear are kept.
- R9: While `ldac_n` is held low, `dac_code` follows each newly completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| din | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select |
| ldac_n | input | 1 | Active-low level-sensitive load |
| clr_n | input | 1 | Active-low clear, acting on its falling edge |
| dac_code | output | 16 | DAC register contents driving the converter |

## Verification
Frames of exactly 16, 12 and 17 bits are sent with asymmetric patterns such as 16'h1234 and 16'h00FF. These show that only full-length frames land, and that bit order is not reversed. Clock toggles with select high, followed by a clean frame, show whether stray edges leak into the shift count. Load pulses taken with clear high and with clear low, plus a sustained low load across two words, separate the three update paths. These paths are the strobe copy, the blocked copy and the level-following copy. Clear is applied both after a loaded word and while a load is pending, which shows that clear wins and that received data survives it.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int DEF_WORD_W = 16;

    // Synchronized control/data pins carried as one bundle
    typedef struct packed {
        logic sclk;
        logic din;
        logic cs_n;
        logic ldac_n;
        logic clr_n;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // Idle levels: clocks low, selects and strobes inactive (high)
    localparam pins_t PINS_IDLE = '{sclk: 1'b0, din: 1'b0, cs_n: 1'b1,
                                    ldac_n: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              cs_n_s,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int               CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER  = CNT_W'(WORD_W + 1);

    logic              sclk_q;
    logic              cs_q;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sreg;
    logic              rise;
    logic              frame_end;

    assign rise      = sclk_s & ~sclk_q;
    assign frame_end = cs_n_s & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            cnt       <= '0;
            sreg      <= '0;
            word_done <= 1'b0;
            word      <= '0;
        end else begin
            sclk_q    <= sclk_s;
            cs_q      <= cs_n_s;
            word_done <= 1'b0;
            if (cs_n_s) begin
                cnt <= '0;
            end else if (rise) begin
                sreg <= {sreg[WORD_W-2:0], din_s};
                if (cnt != OVER) cnt <= cnt + 1'b1;
            end
            if (frame_end && cnt == FULL) begin
                word_done <= 1'b1;
                word      <= sreg;
            end
        end
    end
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic              ldac_n_s,
    input  logic              clr_n_s,
    output logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] dac_code
);
    localparam logic [WORD_W-1:0] MID = {1'b1, {(WORD_W-1){1'b0}}};

    logic clr_q;
    logic clr_fall;

    assign clr_fall = clr_q & ~clr_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q    <= 1'b1;
            in_word  <= MID;
            dac_code <= MID;
        end else begin
            clr_q <= clr_n_s;
            if (word_done) in_word <= word;
            if (clr_fall)
                dac_code <= MID;
            else if (!ldac_n_s && clr_n_s)
                dac_code <= in_word;
        end
    end
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
    import sdac_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              din,
    input  logic              cs_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [WORD_W-1:0] dac_code
);
    pins_t             pin_raw;
    pins_t             pin_s;
    logic              clr_n_s;
    logic              ldac_n_s;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] in_word;

    assign pin_raw = '{sclk: sclk, din: din, cs_n: cs_n,
                       ldac_n: ldac_n, clr_n: clr_n};

    sdac_sync #(
        .W      (PINS_W),
        .STAGES (2),
        .INIT   (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign clr_n_s  = pin_s.clr_n;
    assign ldac_n_s = pin_s.ldac_n;

    sdac_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pin_s.sclk),
        .din_s     (pin_s.din),
        .cs_n_s    (pin_s.cs_n),
        .word_done (word_done),
        .word      (word)
    );

    sdac_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .word_done (word_done),
        .word      (word),
        .ldac_n_s  (ldac_n_s),
        .clr_n_s   (clr_n_s),
        .in_word   (in_word),
        .dac_code  (dac_code)
    );
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_n_s,
    input logic              ldac_n_s,
    input logic [WORD_W-1:0] in_word,
    input logic [WORD_W-1:0] dac_code
);
    localparam logic [WORD_W-1:0] MID = {1'b1, {(WORD_W-1){1'b0}}};

    assert_reset_mid_R1: assert property (@(posedge clk)
        $fell(rst) |-> (dac_code == MID && in_word == MID));

    assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (rst)
        (ldac_n_s && !($past(clr_n_s) && !clr_n_s)) |=> $stable(dac_code));

    assert_load_copies_R3: assert property (@(posedge clk) disable iff (rst)
        (!ldac_n_s && clr_n_s && $past(clr_n_s)) |=> (dac_code == $past(in_word)));

    assert_clear_mid_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_n_s) && !clr_n_s) |=> (dac_code == MID));

    assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr_n_s && !$past(clr_n_s)) |=> $stable(dac_code));
endmodule

bind serial_dac_front sdac_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n_s  (clr_n_s),
    .ldac_n_s (ldac_n_s),
    .in_word  (in_word),
    .dac_code (dac_code)
);

// File: tb/serial_dac_front_bench.sv
module serial_dac_front_bench;
    localparam int W = 16;
    localparam logic [W-1:0] MID = 16'h8000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         din = 1'b0;
    logic         cs_n = 1'b1;
    logic         ldac_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [W-1:0] dac_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_dac_front u_serial_dac_front (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .din      (din),
        .cs_n     (cs_n),
        .ldac_n   (ldac_n),
        .clr_n    (clr_n),
        .dac_code (dac_code)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Send the low n bits of v, highest first, inside one select window
    task automatic send_bits(input logic [31:0] v, input int n);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            din = v[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic pulse_load();
        ldac_n = 1'b0;
        wait_clk(8);
        ldac_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic t_reset();
        wait_clk(2);
        check("R1 reset dac", dac_code, MID);
        pulse_load();
        check("R1 reset input register", dac_code, MID);
    endtask

    task automatic t_frame_no_load();
        send_bits(32'h1234, 16);
        check("R2 frame without load", dac_code, MID);
    endtask

    task automatic t_load();
        pulse_load();
        check("R3 load msb-first word", dac_code, 16'h1234);
    endtask

    task automatic t_short();
        send_bits(32'hABC, 12);
        pulse_load();
        check("R4 short frame ignored", dac_code, 16'h1234);
    endtask

    task automatic t_long();
        send_bits(32'h1BEEF, 17);
        pulse_load();
        check("R5 long frame ignored", dac_code, 16'h1234);
    endtask

    task automatic t_cs_high();
        for (int i = 0; i < 5; i++) begin
            din = 1'b1;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        pulse_load();
        check("R6 edges with cs high", dac_code, 16'h1234);
        send_bits(32'h00FF, 16);
        pulse_load();
        check("R6 clean frame after stray edges", dac_code, 16'h00FF);
    endtask

    task automatic t_clear();
        clr_n = 1'b0;
        wait_clk(6);
        check("R7 clear to midscale", dac_code, MID);
        clr_n = 1'b1;
        wait_clk(6);
        check("R7 stays midscale after release", dac_code, MID);
    endtask

    task automatic t_clear_blocks();
        clr_n = 1'b0;
        wait_clk(6);
        send_bits(32'hBEEF, 16);
        pulse_load();
        check("R8 load blocked during clear", dac_code, MID);
        ldac_n = 1'b0;
        wait_clk(8);
        check("R8 load held during clear", dac_code, MID);
        clr_n = 1'b1;
        wait_clk(6);
        check("R8 pending load after release", dac_code, 16'hBEEF);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_follow();
        ldac_n = 1'b0;
        wait_clk(6);
        send_bits(32'h0001, 16);
        check("R9 follow first word", dac_code, 16'h0001);
        send_bits(32'hFFFF, 16);
        check("R9 follow second word", dac_code, 16'hFFFF);
        ldac_n = 1'b1;
        wait_clk(6);
        send_bits(32'h5555, 16);
        check("R2 no update after load released", dac_code, 16'hFFFF);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        t_reset();
        t_frame_no_load();
        t_load();
        t_short();
        t_long();
        t_cs_high();
        t_clear();
        t_clear_blocks();
        t_follow();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before tests finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule